// File: doc/BRIEF.md
# Shared Interrupt Source Conditioning Unit

This block sits between a bank of shared external interrupt lines and the routing logic that forwards them to processors. Each line is first brought into the local clock domain. It is then qualified by its own configuration: active polarity, level or edge sensing, and optional detection on both edges. The result is gated by a per-line enable mask to form a pending vector. Routing logic downstream consumes that vector directly.

Software reaches the unit over a small word-addressed register bus. The bus has a write strobe and a read strobe, and read data is returned in the same cycle. The enable mask is changed only through two write-one ports, one that sets enable bits and one that clears them, so no read-modify-write is needed. A single command word can set or clear the edge latch of any one line. Software uses it to acknowledge an edge interrupt or to raise one on purpose.

Edge latches keep recording events while their line is disabled. Enabling the line later makes the stored event appear at once.

Top module: `irq_cond_unit`

## Requirements
- R1: After reset, all configuration bits, mask bits and edge latches are 0, `pend_o` is 0, and every readable word reads 0.
- R2: A level line (type bit 0) is active when its synchronized input equals its polarity bit: 1 means high-active, 0 means low-active. Its pending bit follows the input two clock edges after the input changes and keeps no memory.
- R3: An edge line (type bit 1, dual bit 0) with polarity 1 latches on a rising input and with polarity 0 on a falling input. The pending bit rises three clock edges after the input transition.
- R4: An edge line with its dual bit set latches on both rising and falling transitions, and polarity has no effect.
- R5: Word 4 is the mask-set port and word 5 the mask-clear port. A 1 in a written bit sets or clears that line's enable, and a 0 leaves it unchanged. Both words read back as 0.
- R6: Word 6 reads the enable mask, where 1 means enabled. Word 7 reads the pending vector, which equals `pend_o`: a line is pending when it is enabled and active.
- R7: A write to word 3 is an edge command. Bit 31 selects set (1) or clear (0), and bits [4:0] give the line number. The change is visible from the next cycle.
- R8: An edge latch stays set until an edge command clears it, however the input moves afterwards.
- R9: When a hardware edge and a clear command hit the same latch on the same clock edge, the latch ends up set.
- R10: An edge latch captures events while its line is disabled. The pending bit rises in the cycle after the mask-set write enables the line.
- R11: Words 0, 1 and 2 hold polarity, type and dual-edge bits and read back as written. `rdata` is combinational with `rd_en` and is 0 while `rd_en` is low.
- R12: Setting the edge latch of a level line has no effect on its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, same cycle as `rd_en` |
| pend_o | output | NUM_LINES | Pending vector to the routing logic |

## Verification
The assertions assume that the bus strobes and address are at known values once reset is released. They also assume that an edge command names a line number below the line count, so every command reaches a real latch. The bench changes the raw lines and the bus signals only on the falling clock edge. It issues edge commands only for lines 0 to 31. It times the one deliberate collision between a clear command and a hardware edge so that both land on the same rising edge.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int REG_POL       = 0;
  localparam int REG_TRIG      = 1;
  localparam int REG_DUAL      = 2;
  localparam int REG_EDGE_CMD  = 3;
  localparam int REG_MASK_SET  = 4;
  localparam int REG_MASK_CLR  = 5;
  localparam int REG_MASK_STAT = 6;
  localparam int REG_PEND_STAT = 7;
  localparam int CMD_OP_BIT    = 31;

  // transition qualified by polarity, or either transition in dual mode
  function automatic logic edge_hit(logic pol, logic dual, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // level line active when its sample matches the polarity bit
  function automatic logic level_active(logic pol, logic cur);
    return ~(pol ^ cur);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_cond_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic en_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic evt_o,
  output logic latch_o,
  output logic pend_o
);
  logic prev_q;
  logic latch_q;

  assign evt_o = trig_i & edge_hit(pol_i, dual_i, lvl_i, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      // a hardware event overrides a same-cycle clear
      latch_q <= evt_o | sw_set_i | (latch_q & ~sw_clr_i);
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = en_i & (trig_i ? latch_q : level_active(pol_i, lvl_i));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_cond_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      pend_i,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      trig_o,
  output logic [N-1:0]      dual_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      sw_set_o,
  output logic [N-1:0]      sw_clr_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] pol_q, trig_q, dual_q, mask_q;
  logic         cmd_wr;
  logic [IDX_W-1:0] cmd_idx;

  function automatic logic [DATA_W-1:0] widen(logic [N-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  assign cmd_wr  = wr_en && (addr == ADDR_W'(REG_EDGE_CMD));
  assign cmd_idx = wdata[IDX_W-1:0];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sw_set_o[i] = cmd_wr && (cmd_idx == IDX_W'(i)) &&  wdata[CMD_OP_BIT];
      sw_clr_o[i] = cmd_wr && (cmd_idx == IDX_W'(i)) && !wdata[CMD_OP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(REG_POL))      pol_q  <= wdata[N-1:0];
      if (addr == ADDR_W'(REG_TRIG))     trig_q <= wdata[N-1:0];
      if (addr == ADDR_W'(REG_DUAL))     dual_q <= wdata[N-1:0];
      if (addr == ADDR_W'(REG_MASK_SET)) mask_q <= mask_q | wdata[N-1:0];
      if (addr == ADDR_W'(REG_MASK_CLR)) mask_q <= mask_q & ~wdata[N-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(REG_POL):       rdata = widen(pol_q);
        ADDR_W'(REG_TRIG):      rdata = widen(trig_q);
        ADDR_W'(REG_DUAL):      rdata = widen(dual_q);
        ADDR_W'(REG_MASK_STAT): rdata = widen(mask_q);
        ADDR_W'(REG_PEND_STAT): rdata = widen(pend_i);
        default:                rdata = '0;
      endcase
    end
  end

  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign dual_o = dual_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_cond_unit.sv
module irq_cond_unit #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] lvl_w, pol_w, trig_w, dual_w, mask_w;
  logic [NUM_LINES-1:0] sw_set_w, sw_clr_w, evt_w, latch_w, pend_w;

  irq_sync #(.N(NUM_LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(irq_in), .q_o(lvl_w)
  );

  irq_cfg_regs #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pend_i(pend_w), .rdata(rdata), .pol_o(pol_w),
    .trig_o(trig_w), .dual_o(dual_w), .mask_o(mask_w),
    .sw_set_o(sw_set_w), .sw_clr_o(sw_clr_w)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line line_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w[g]), .pol_i(pol_w[g]),
      .trig_i(trig_w[g]), .dual_i(dual_w[g]), .en_i(mask_w[g]),
      .sw_set_i(sw_set_w[g]), .sw_clr_i(sw_clr_w[g]),
      .evt_o(evt_w[g]), .latch_o(latch_w[g]), .pend_o(pend_w[g])
    );
  end

  assign pend_o = pend_w;
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk
  import irq_cond_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      latch_q,
  input logic [N-1:0]      edge_evt,
  input logic [N-1:0]      sw_clr,
  input logic [N-1:0]      trig_q
);
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(REG_MASK_SET)) |=>
      ((mask_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(REG_MASK_CLR)) |=>
      ((mask_q & $past(wdata[N-1:0])) == '0));

  p_latch_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q) & ~$past(sw_clr) & ~latch_q) == '0));

  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_evt) & ~latch_q) == '0));

  p_level_no_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt & ~trig_q) == '0);

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind irq_cond_unit irq_cond_chk #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mask_q(mask_w), .latch_q(latch_w),
  .edge_evt(evt_w), .sw_clr(sw_clr_w), .trig_q(trig_w)
);

// File: tb/irq_cond_unit_tb.sv
module irq_cond_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] pend_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] mask_m, pol_m, v_old, v_new, rv, exp_v;

  always #10 clk = ~clk;

  irq_cond_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pend_o(pend_o)
  );

  function automatic logic [31:0] nxt(logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_en = 1'b1; addr = 3'(a);
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 32; i++) wr(3, 32'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 pend", pend_o, '0);
    for (int a = 0; a < 8; a++) begin
      rd(a, rv);
      chk("R1 read", rv, '0);
    end

    // R11 configuration readback and idle read data
    wr(0, 32'hA5A5_0F0F); wr(1, 32'h3C3C_1234); wr(2, 32'h8001_FFFF);
    rd(0, rv); chk("R11 pol", rv, 32'hA5A5_0F0F);
    rd(1, rv); chk("R11 trig", rv, 32'h3C3C_1234);
    rd(2, rv); chk("R11 dual", rv, 32'h8001_FFFF);
    addr = 3'd0; #1 chk("R11 idle rdata", rdata, '0);
    wr(0, 0); wr(1, 0); wr(2, 0);

    // R5 / R6 mask ports
    wr(4, 32'hFFFF_0000); wr(4, 32'h0000_00FF); wr(5, 32'h00F0_00F0);
    mask_m = (32'hFFFF_0000 | 32'h0000_00FF) & ~32'h00F0_00F0;
    rd(6, rv); chk("R6 mask stat", rv, mask_m);
    rd(4, rv); chk("R5 set port reads 0", rv, '0);
    rd(5, rv); chk("R5 clr port reads 0", rv, '0);
    wr(4, 32'hFFFF_FFFF);
    rd(6, rv); chk("R5 mask all", rv, 32'hFFFF_FFFF);

    // R2 level sweep
    for (int k = 0; k < 8; k++) begin
      seed = nxt(seed); pol_m = seed;
      seed = nxt(seed); v_new = seed;
      v_old = irq_in;
      wr(0, pol_m);
      irq_in = v_new;
      step(1);
      chk("R2 level not yet", pend_o, ~(v_old ^ pol_m));
      step(1);
      chk("R2 level", pend_o, ~(v_new ^ pol_m));
      rd(7, rv); chk("R6 pend stat", rv, ~(v_new ^ pol_m));
    end

    // R12 latch set on level line
    exp_v = pend_o;
    wr(3, 32'h8000_0005);
    step(1);
    chk("R12 level ignores latch", pend_o, exp_v);
    clear_all();

    // R3 single-edge sweep
    wr(1, 32'hFFFF_FFFF); wr(2, 0);
    chk("R3 no spurious", pend_o, '0);
    for (int k = 0; k < 8; k++) begin
      seed = nxt(seed); pol_m = seed;
      seed = nxt(seed); v_new = seed;
      v_old = irq_in;
      wr(0, pol_m);
      irq_in = v_new;
      step(2);
      chk("R3 edge not yet", pend_o, '0);
      step(1);
      chk("R3 edge", pend_o, (v_new & ~v_old & pol_m) | (~v_new & v_old & ~pol_m));
      clear_all();
      chk("R7 clear all", pend_o, '0);
    end

    // R4 dual-edge sweep
    wr(2, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      seed = nxt(seed); pol_m = seed;
      seed = nxt(seed); v_new = seed;
      v_old = irq_in;
      wr(0, pol_m);
      irq_in = v_new;
      step(3);
      chk("R4 dual", pend_o, v_new ^ v_old);
      clear_all();
    end

    // R8 sticky latch, R7 commands
    wr(2, 0); wr(0, 32'hFFFF_FFFF);
    irq_in = '0; step(3); clear_all();
    irq_in[3] = 1'b1; step(3);
    irq_in[3] = 1'b0; step(20);
    chk("R8 sticky", pend_o, 32'h0000_0008);
    wr(3, 32'h0000_0003);
    chk("R7 clear cmd", pend_o, '0);
    wr(3, 32'h8000_0011);
    chk("R7 set cmd", pend_o, 32'h0002_0000);
    wr(3, 32'h0000_0011);
    chk("R7 clear line 17", pend_o, '0);

    // R9 hardware edge beats same-cycle clear
    irq_in[9] = 1'b1;
    step(2);
    wr(3, 32'h0000_0009);
    chk("R9 hw wins", pend_o, 32'h0000_0200);
    wr(3, 32'h0000_0009);
    chk("R9 clear after", pend_o, '0);

    // R10 masked capture
    wr(5, 32'h0000_1000);
    irq_in[12] = 1'b1;
    step(3);
    chk("R10 masked", pend_o, '0);
    wr(4, 32'h0000_1000);
    chk("R10 unmask", pend_o, 32'h0000_1000);
    rd(7, rv); chk("R10 pend stat", rv, 32'h0000_1000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule